// File: doc/BRIEF.md
# I2C Register Write Target

This block is a bus target for a two-wire serial bus with 7-bit addressing. It gives an external bus controller write-only access to a local register memory. Both bus lines are oversampled by the system clock. Each line passes through a synchronizer and a glitch filter before any edge is detected. The block answers by pulling the data line low through an open-drain enable.

Three strap pins are captured once after reset. They form the low three bits of the target address, and the upper four bits are fixed at `0100`. A write transaction carries three things: a 16-bit register pointer sent low byte first, then any number of data bytes, then a STOP. The data bytes go to consecutive memory locations. The STOP hands the command to downstream logic through an active-low busy output, and downstream logic ends the command with a one-cycle done pulse.

Top module: `i2c_regwr_target`

## Requirements
- R1: The byte after a START is accepted when its bits 7..1 equal `0100` followed by the captured straps (bit 3 = strap[2], bit 2 = strap[1], bit 1 = strap[0]) and bit 0 (write flag) is 0. An accepted byte is acknowledged by driving `sda_oe` high during the ninth SCL clock.
- R2: The straps are captured once, in the first clock after reset is released. Later changes on `strap_i` do not change the address the block responds to.
- R3: A byte after a START that does not match gets no acknowledge. Later bytes up to the next START or STOP get no acknowledge and cause no memory write.
- R4: A matching address byte with bit 0 set (read) gets no acknowledge.
- R5: After an accepted address, the next byte is the pointer low byte and the byte after it is the pointer high byte. Each is acknowledged.
- R6: Each data byte is acknowledged and written with a single-cycle `mem_we` pulse at the current pointer. The pointer then increments by one and wraps from 0xFFFF to 0x0000.
- R7: A STOP in a transaction whose pointer was fully received drives `busy_n` low. `busy_n` stays low until `cmd_done_i` is sampled high.
- R8: A transaction that ends before the pointer high byte writes no memory and leaves `busy_n` high.
- R9: While `busy_n` is low, address bytes are not acknowledged and no memory write takes place.
- R10: A repeated START restarts address reception. The pointer and data that follow it are handled as in R5 and R6.
- R11: `sda_oe` changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When high, the data line is pulled low (acknowledge) |
| strap_i | input | 3 | Address strap pins, captured after reset |
| busy_n | output | 1 | Low while a received command awaits completion |
| cmd_done_i | input | 1 | Pulse from downstream logic that ends the command |
| mem_we | output | 1 | Memory write strobe, one cycle per data byte |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 8 | Memory write data |

## Verification
The hardest case to reach is a repeated START that cuts off a transaction after only the pointer low byte. The block must drop that half-built pointer, accept a fresh address, and write only at the new pointer. The bench reaches this by opening a transaction, sending the low pointer byte, raising SDA while SCL is low, and forcing a START with no STOP in between. A second hard case is an address byte that arrives while the block is still busy. The bench reaches it by sending a full write transaction and holding back `cmd_done_i` during the next transaction.

// File: rtl/i2c_regwr_pkg.sv
package i2c_regwr_pkg;

    localparam int PTR_W  = 16;
    localparam int DATA_W = 8;
    localparam int BIT_W  = 4;
    localparam logic [3:0] ADDR_FIXED = 4'b0100;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_PTR_LO,
        PH_PTR_HI,
        PH_DATA,
        PH_IGNORE
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        phase_e             after;
        logic [BIT_W-1:0]   bitc;
        logic [DATA_W-1:0]  shreg;
        logic [PTR_W-1:0]   ptr;
        logic               ack_pend;
        logic               oe;
        logic               armed;
        logic               busy;
        logic               we;
        logic [PTR_W-1:0]   waddr;
        logic [DATA_W-1:0]  wdata;
    } eng_t;

endpackage

// File: rtl/i2c_rw_filter.sv
module i2c_rw_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CNT_W = $clog2(FILT_CYCLES + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       cnt_d, cnt_q;
    logic                   out_d, out_q;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q[g] <= 1'b1;
                end else if (g == 0) begin
                    sync_q[g] <= line_i;
                end else begin
                    sync_q[g] <= sync_q[(g > 0) ? g - 1 : 0];
                end
            end
        end
    endgenerate

    always_comb begin
        out_d = out_q;
        cnt_d = '0;
        if (sync_q[SYNC_STAGES-1] != out_q) begin
            if (cnt_q == CNT_W'(FILT_CYCLES - 1)) begin
                out_d = sync_q[SYNC_STAGES-1];
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b1;
            cnt_q <= '0;
        end else begin
            out_q <= out_d;
            cnt_q <= cnt_d;
        end
    end

    assign line_o = out_q;

endmodule

// File: rtl/i2c_rw_events.sv
module i2c_rw_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_evt,
    output logic stop_evt,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_f;
            sda_p_q <= sda_f;
        end
    end

    assign start_evt = scl_p_q & scl_f & sda_p_q & ~sda_f;
    assign stop_evt  = scl_p_q & scl_f & ~sda_p_q & sda_f;
    assign scl_rise  = ~scl_p_q & scl_f;
    assign scl_fall  = scl_p_q & ~scl_f;

endmodule

// File: rtl/i2c_rw_engine.sv
module i2c_rw_engine
    import i2c_regwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_f,
    input  logic [2:0]        strap_q,
    input  logic              done_i,
    output logic              oe_o,
    output logic              busy_o,
    output logic              we_o,
    output logic [PTR_W-1:0]  waddr_o,
    output logic [DATA_W-1:0] wdata_o
);
    eng_t q, d;
    logic [DATA_W-1:0] byte_in;
    logic              addr_hit;

    assign byte_in  = {q.shreg[DATA_W-2:0], sda_f};
    assign addr_hit = (byte_in[7:1] == {ADDR_FIXED, strap_q}) && !byte_in[0] && !q.busy;

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (done_i) begin
            d.busy = 1'b0;
        end
        if (stop_evt) begin
            d.phase = PH_IDLE;
            d.oe    = 1'b0;
            d.bitc  = '0;
            d.armed = 1'b0;
            if (q.armed) begin
                d.busy = 1'b1;
            end
        end else if (start_evt) begin
            d.phase = PH_ADDR;
            d.bitc  = '0;
            d.oe    = 1'b0;
        end else if (q.phase != PH_IDLE && q.phase != PH_IGNORE) begin
            if (scl_rise) begin
                if (q.bitc < BIT_W'(8)) begin
                    d.shreg = byte_in;
                    d.bitc  = q.bitc + 1'b1;
                    if (q.bitc == BIT_W'(7)) begin
                        d.ack_pend = 1'b1;
                        unique case (q.phase)
                            PH_ADDR: begin
                                d.ack_pend = addr_hit;
                                d.after    = addr_hit ? PH_PTR_LO : PH_IGNORE;
                            end
                            PH_PTR_LO: begin
                                d.ptr[7:0] = byte_in;
                                d.after    = PH_PTR_HI;
                            end
                            PH_PTR_HI: begin
                                d.ptr[15:8] = byte_in;
                                d.armed     = 1'b1;
                                d.after     = PH_DATA;
                            end
                            default: begin
                                d.we    = 1'b1;
                                d.waddr = q.ptr;
                                d.wdata = byte_in;
                                d.ptr   = q.ptr + 1'b1;
                                d.after = PH_DATA;
                            end
                        endcase
                    end
                end else begin
                    d.bitc = BIT_W'(9);
                end
            end else if (scl_fall) begin
                if (q.bitc == BIT_W'(8)) begin
                    d.oe = q.ack_pend;
                    if (!q.ack_pend) begin
                        d.phase = PH_IGNORE;
                    end
                end else if (q.bitc == BIT_W'(9)) begin
                    d.oe    = 1'b0;
                    d.bitc  = '0;
                    d.phase = q.after;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, after: PH_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign oe_o    = q.oe;
    assign busy_o  = q.busy;
    assign we_o    = q.we;
    assign waddr_o = q.waddr;
    assign wdata_o = q.wdata;

endmodule

// File: rtl/i2c_regwr_target.sv
module i2c_regwr_target
    import i2c_regwr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        strap_i,
    output logic              busy_n,
    input  logic              cmd_done_i,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    logic       scl_f, sda_f;
    logic       start_evt, stop_evt, scl_rise, scl_fall;
    logic [2:0] strap_d, strap_q;
    logic       strap_vld_d, strap_vld_q;
    logic       busy;

    i2c_rw_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYCLES(FILT_CYCLES)) u_scl_flt (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f)
    );

    i2c_rw_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYCLES(FILT_CYCLES)) u_sda_flt (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f)
    );

    i2c_rw_events u_evt (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    always_comb begin
        strap_d     = strap_q;
        strap_vld_d = 1'b1;
        if (!strap_vld_q) begin
            strap_d = strap_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_q     <= '0;
            strap_vld_q <= 1'b0;
        end else begin
            strap_q     <= strap_d;
            strap_vld_q <= strap_vld_d;
        end
    end

    i2c_rw_engine u_eng (
        .clk(clk), .rst_n(rst_n),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_f(sda_f),
        .strap_q(strap_q), .done_i(cmd_done_i),
        .oe_o(sda_oe), .busy_o(busy), .we_o(mem_we),
        .waddr_o(mem_addr), .wdata_o(mem_wdata)
    );

    assign busy_n = ~busy;

endmodule

// File: rtl/i2c_regwr_checker.sv
module i2c_regwr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       scl_f,
    input logic       busy_n,
    input logic       cmd_done_i,
    input logic       stop_evt,
    input logic       mem_we,
    input logic [2:0] strap_q,
    input logic       strap_vld_q
);
    a_r11_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);

    a_r7_busy_ends_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> $past(cmd_done_i));

    a_r7_busy_starts_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_n) |-> $past(stop_evt));

    a_r9_no_write_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy_n);

    a_r6_single_cycle_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    a_r2_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_vld_q && $past(strap_vld_q)) |-> $stable(strap_q));

endmodule

bind i2c_regwr_target i2c_regwr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_f(scl_f),
    .busy_n(busy_n), .cmd_done_i(cmd_done_i), .stop_evt(stop_evt),
    .mem_we(mem_we), .strap_q(strap_q), .strap_vld_q(strap_vld_q)
);

// File: tb/i2c_regwr_target_bench.sv
module i2c_regwr_target_bench;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_b = 1'b1;
    logic        sda_b = 1'b1;
    logic [2:0]  strap = 3'b000;
    logic        done = 1'b0;
    logic        sda_oe, busy_n, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        sda_line;

    int  total = 0;
    int  bad = 0;
    bit  fin = 1'b0;
    bit  model_busy = 1'b0;
    bit  model_armed = 1'b0;
    logic [2:0]  model_strap;
    logic [23:0] expq[$];

    always #2.5 clk = ~clk;

    assign sda_line = sda_b & ~sda_oe;

    i2c_regwr_target u_i2c_regwr_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_b), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_i(strap), .busy_n(busy_n),
        .cmd_done_i(done), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // every-clock comparison of memory writes against the model queue (R6, R8, R3, R9)
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (expq.size() == 0) begin
                chk("R6 unexpected write addr", int'(mem_addr), -1);
            end else begin
                logic [23:0] e;
                e = expq.pop_front();
                chk("R6 write address", int'(mem_addr), int'(e[23:8]));
                chk("R6 write data", int'(mem_wdata), int'(e[7:0]));
            end
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_b = 1'b0; wq(2*Q);
        scl_b = 1'b0; wq(Q);
    endtask

    task automatic bus_rstart();
        sda_b = 1'b1; wq(Q);
        scl_b = 1'b1; wq(Q);
        sda_b = 1'b0; wq(Q);
        scl_b = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_b = 1'b0; wq(Q);
        scl_b = 1'b1; wq(Q);
        sda_b = 1'b1; wq(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_b = b[i]; wq(Q);
            scl_b = 1'b1; wq(2*Q);
            scl_b = 1'b0; wq(Q);
        end
        sda_b = 1'b1; wq(Q);
        scl_b = 1'b1; wq(Q);
        acked = !sda_line;
        wq(Q);
        scl_b = 1'b0; wq(Q);
    endtask

    task automatic frame(input bit rs, input logic [7:0] abyte, input logic [15:0] ptr,
                         input int nptr, input int ndata, input logic [7:0] seed,
                         input bit do_stop, input string tag);
        bit ack, hit;
        logic [15:0] p;
        hit = (abyte[7:1] == {4'b0100, model_strap}) && !abyte[0] && !model_busy;
        if (rs) bus_rstart(); else bus_start();
        send_byte(abyte, ack);
        chk({tag, " address ack"}, int'(ack), int'(hit));
        if (nptr >= 1) begin
            send_byte(ptr[7:0], ack);
            chk({tag, " R5 pointer low ack"}, int'(ack), int'(hit));
        end
        if (nptr >= 2) begin
            send_byte(ptr[15:8], ack);
            chk({tag, " R5 pointer high ack"}, int'(ack), int'(hit));
            if (hit) model_armed = 1'b1;
            p = ptr;
            for (int k = 0; k < ndata; k++) begin
                if (hit) expq.push_back({p, seed + 8'(k)});
                send_byte(seed + 8'(k), ack);
                chk({tag, " R6 data ack"}, int'(ack), int'(hit));
                p = p + 16'd1;
            end
        end
        if (do_stop) begin
            bus_stop();
            if (model_armed) model_busy = 1'b1;
            model_armed = 1'b0;
            wq(20);
            chk({tag, " R7 busy after stop"}, int'(busy_n), int'(!model_busy));
            chk({tag, " R6 writes drained"}, expq.size(), 0);
        end
    endtask

    task automatic finish_cmd();
        wq(100);
        chk("R7 busy held until done", int'(busy_n), 0);
        done = 1'b1; wq(1);
        done = 1'b0; wq(3);
        model_busy = 1'b0;
        chk("R7 busy released after done", int'(busy_n), 1);
    endtask

    initial begin
        strap = 3'b101;
        model_strap = 3'b101;
        wq(5);
        chk("reset busy_n", int'(busy_n), 1);
        chk("reset sda_oe", int'(sda_oe), 0);
        chk("reset mem_we", int'(mem_we), 0);
        rst_n = 1'b1;
        wq(3);
        strap = 3'b010;
        wq(20);

        // R1 R5 R6 R7: plain write transaction
        frame(1'b0, 8'h4A, 16'h1234, 2, 3, 8'hA0, 1'b1, "R1");
        finish_cmd();

        // R2 R3: address formed from the new pin value must be refused, its data ignored
        frame(1'b0, {4'b0100, 3'b010, 1'b0}, 16'h0010, 2, 2, 8'h11, 1'b1, "R2 R3");

        // R3: other fixed bits
        frame(1'b0, 8'h9A, 16'h0020, 2, 1, 8'h22, 1'b1, "R3");

        // R4: read flag set
        frame(1'b0, 8'h4B, 16'h0030, 2, 1, 8'h33, 1'b1, "R4");

        // R6 wrap-around
        frame(1'b0, 8'h4A, 16'hFFFE, 2, 3, 8'h70, 1'b1, "R6 wrap");
        finish_cmd();

        // R8: only the low pointer byte, then STOP
        frame(1'b0, 8'h4A, 16'h0040, 1, 0, 8'h00, 1'b1, "R8");

        // R8: address only, then STOP
        frame(1'b0, 8'h4A, 16'h0000, 0, 0, 8'h00, 1'b1, "R8 addr only");

        // R9: busy blocks a new transaction
        frame(1'b0, 8'h4A, 16'h0100, 2, 1, 8'h5C, 1'b1, "R7");
        frame(1'b0, 8'h4A, 16'h0200, 2, 2, 8'h66, 1'b1, "R9");
        finish_cmd();

        // R10: repeated START after a half pointer
        frame(1'b0, 8'h4A, 16'h0055, 1, 0, 8'h00, 1'b0, "R10 first");
        frame(1'b1, 8'h4A, 16'h0400, 2, 2, 8'hC3, 1'b1, "R10");
        finish_cmd();

        wq(10);
        chk("R6 queue empty at end", expq.size(), 0);
        fin = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule